// File: doc/BRIEF.md
# Fault Graph Builder for Spare Row/Column Allocation

This block sits between a memory self-test engine and a spare-allocation solver. While the test runs, the engine reports each failing cell as a row address and a column address. The block keeps a small table of the distinct failing rows and a second table of the distinct failing columns. Each table entry becomes a vertex of a bipartite fault graph, numbered in the order the entries were first seen. For every reported cell, the block sets the bit that joins its row vertex and its column vertex.

The solver reads the result as a full square connection matrix over all vertices. Row vertices come first and column vertices follow them. The matrix is symmetric and its diagonal is zero. The solver also reads the original address behind each vertex, so a chosen cover can be mapped back to physical rows and columns.

A fault that would need a vertex when its table is already full is dropped whole, and a sticky flag reports this. An end-of-test pulse freezes the graph. A clear pulse empties the graph for the next run.

Top module: `fault_graph_mapper`

## Requirements
- R1: After a cycle with reset low, or after a cycle with `clear_i` high, both used masks are 0, every bit of `conn_o` is 0, and `overflow_o` is 0. `clear_i` takes priority over a fault or a done pulse presented in the same cycle.
- R2: A failing row address that is not yet stored takes the lowest free row slot k, with k from 0 to ROW_SLOTS-1. Slots fill in order of arrival. Bit k of `row_used_o` goes to 1, and the address appears at `row_addr_o[k*ROW_AW +: ROW_AW]`.
- R3: Column addresses follow the same rule in their own table, using `col_used_o` and `col_addr_o`. Column slot k is graph vertex ROW_SLOTS+k, and row slot k is vertex k.
- R4: A fault whose row address, or whose column address, is already stored reuses that slot and allocates no new one. No address is ever held in two slots of the same table.
- R5: The connection bit for vertices i and j is `conn_o[i*N + j]`, where N = ROW_SLOTS+COL_SLOTS. A row/column pair bit is 1 exactly when a fault at that row and column has been recorded since the last clear.
- R6: `conn_o` is symmetric, its diagonal is 0, and every row-to-row and column-to-column bit is 0.
- R7: A fault that needs a new row slot while all row slots are used, or a new column slot while all column slots are used, is discarded entirely: no slot and no bit changes. `overflow_o` is then set and stays set until a clear.
- R8: Reporting a fault that is already recorded leaves every output unchanged.
- R9: A fault presented in the same cycle as `done_i` is still recorded. Faults in later cycles are ignored until the next clear.
- R10: A fault sampled at a rising clock edge is visible at the outputs right after that edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear_i | input | 1 | Empty the graph and clear the flag and the freeze |
| done_i | input | 1 | End of test; freezes the graph after this cycle |
| flt_vld_i | input | 1 | A failing cell is presented |
| flt_row_i | input | ROW_AW | Row address of the failing cell |
| flt_col_i | input | COL_AW | Column address of the failing cell |
| row_addr_o | output | ROW_SLOTS*ROW_AW | Row address held by each row slot |
| col_addr_o | output | COL_SLOTS*COL_AW | Column address held by each column slot |
| row_used_o | output | ROW_SLOTS | Row slot occupied mask |
| col_used_o | output | COL_SLOTS | Column slot occupied mask |
| conn_o | output | N*N | Full vertex connection matrix, bit i*N+j |
| overflow_o | output | 1 | Sticky flag: a fault was dropped for lack of a slot |

## Verification
The hardest case to reach from the ports is an overflow where only one dimension is short of slots. For example, the row table is full and the new fault's row is new, while its column is also new and the column table still has room. The bench must show that the column table stays untouched. To reach this, random faults draw rows and columns from two small address pools that are slightly larger than the slot counts, so the tables fill quickly and then see a mix of hits and misses. Directed steps force a full row table with a free column slot. Other directed steps drive a clear or a done pulse in the same cycle as a fault.

// File: rtl/fgm_pkg.sv
// Shared helpers for the fault graph builder.
// Assumes: slot counts are at least 1.
package fgm_pkg;

    // Width of an index into n slots; never below one bit.
    function automatic int idx_w(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    // What the top level does with the presented fault this cycle.
    typedef enum logic [1:0] {
        ACT_NONE     = 2'd0,
        ACT_RECORD   = 2'd1,
        ACT_OVERFLOW = 2'd2
    } fgm_act_e;

endpackage

// File: rtl/fgm_slot_table.sv
// Table of distinct addresses, filled in order of arrival.
// A parallel compare against every used slot finds a hit. Allocation
// writes the next free slot.
// Assumes: the caller raises alloc_i only on a miss with a free slot.
module fgm_slot_table
    import fgm_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int AW    = 10,
    localparam int IW   = idx_w(SLOTS),
    localparam int CW   = $clog2(SLOTS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               alloc_i,
    input  logic [AW-1:0]      key_i,
    output logic               hit_o,
    output logic [IW-1:0]      hit_idx_o,
    output logic               full_o,
    output logic [IW-1:0]      free_idx_o,
    output logic [SLOTS*AW-1:0] addr_o,
    output logic [SLOTS-1:0]   used_o
);

    logic [AW-1:0]    addr_q [SLOTS];
    logic [CW-1:0]    cnt_q;
    logic [SLOTS-1:0] match;

    // Per-slot used bit, address compare and flat output.
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign used_o[g]            = (cnt_q > CW'(g));
        assign match[g]             = used_o[g] && (addr_q[g] == key_i);
        assign addr_o[g*AW +: AW]   = addr_q[g];
    end

    assign hit_o      = |match;
    assign full_o     = (cnt_q == CW'(SLOTS));
    assign free_idx_o = cnt_q[IW-1:0];

    // Encode the matching slot; at most one slot can match.
    always_comb begin
        hit_idx_o = '0;
        for (int k = SLOTS - 1; k >= 0; k--) begin
            if (match[k]) hit_idx_o = IW'(k);
        end
    end

    // Fill counter: cleared by reset or clear, bumped on allocation.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)            cnt_q <= '0;
        else if (alloc_i && !full_o)      cnt_q <= cnt_q + 1'b1;
    end

    // Address storage: written only into the next free slot.
    always_ff @(posedge clk) begin
        if (alloc_i && !full_o) addr_q[free_idx_o] <= key_i;
    end

    // The caller must never allocate on a hit or into a full table.
    p_alloc_only_new_r4: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> (!hit_o && !full_o));

    // Each allocation adds exactly one used slot.
    p_fill_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i && !clear_i) |=> ($countones(used_o) == $countones($past(used_o)) + 1));

    // No address is held twice.
    for (genvar a = 0; a < SLOTS; a++) begin : g_ua
        for (genvar b = a + 1; b < SLOTS; b++) begin : g_ub
            p_unique_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
                used_o[b] |-> (addr_q[a] != addr_q[b]));
        end
    end

endmodule

// File: rtl/fgm_adj_matrix.sv
// Row-by-column fault adjacency bits, flat with bit r*COLS+c.
// Bits are only set, never cleared individually; clear empties all.
// Assumes: row_idx_i < ROWS and col_idx_i < COLS whenever set_i is high.
module fgm_adj_matrix
    import fgm_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    localparam int RIW = idx_w(ROWS),
    localparam int CIW = idx_w(COLS),
    localparam int NB  = ROWS * COLS
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear_i,
    input  logic           set_i,
    input  logic [RIW-1:0] row_idx_i,
    input  logic [CIW-1:0] col_idx_i,
    output logic [NB-1:0]  adj_o
);

    logic [NB-1:0] adj_q;
    logic [NB-1:0] set_vec;

    // Decode the crossing to set into a one-hot vector.
    always_comb begin
        set_vec = '0;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                if (set_i && (int'(row_idx_i) == r) && (int'(col_idx_i) == c))
                    set_vec[r*COLS + c] = 1'b1;
            end
        end
    end

    // Adjacency storage: clear empties all, a record ORs in one bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) adj_q <= '0;
        else                   adj_q <= adj_q | set_vec;
    end

    assign adj_o = adj_q;

    // A recorded crossing is present on the next cycle.
    p_set_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clear_i) |=> ((adj_o & $past(set_vec)) == $past(set_vec)));

    // Without a clear, no bit ever falls.
    p_bits_only_grow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> ((adj_o & $past(adj_o)) == $past(adj_o)));

endmodule

// File: rtl/fgm_conn_expand.sv
// Expands the row-by-column bits into the full vertex connection matrix.
// Row vertices come first, then column vertices. Purely combinational.
// Assumes: adj_i bit r*COLS+c joins row slot r and column slot c.
module fgm_conn_expand #(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    localparam int N   = ROWS + COLS
) (
    input  logic [ROWS*COLS-1:0] adj_i,
    output logic [N*N-1:0]       conn_o
);

    // Place each entry: the upper block is taken directly, the lower
    // block is the mirror of it, and all other entries are zero.
    for (genvar i = 0; i < N; i++) begin : g_i
        for (genvar j = 0; j < N; j++) begin : g_j
            if (i < ROWS && j >= ROWS) begin : g_up
                assign conn_o[i*N + j] = adj_i[i*COLS + (j - ROWS)];
            end else if (i >= ROWS && j < ROWS) begin : g_lo
                assign conn_o[i*N + j] = adj_i[j*COLS + (i - ROWS)];
            end else begin : g_zero
                assign conn_o[i*N + j] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/fault_graph_mapper.sv
// Builds a compact bipartite fault graph from failing-cell reports.
// Distinct rows and columns get slots in order of arrival, and the
// crossing bits are set. A fault that cannot fit is dropped and flagged.
// A done pulse freezes the graph; a clear empties it.
// Assumes: one fault report per cycle at most.
module fault_graph_mapper
    import fgm_pkg::*;
#(
    parameter int ROW_AW    = 10,
    parameter int COL_AW    = 10,
    parameter int ROW_SLOTS = 4,
    parameter int COL_SLOTS = 4,
    localparam int N        = ROW_SLOTS + COL_SLOTS,
    localparam int RIW      = idx_w(ROW_SLOTS),
    localparam int CIW      = idx_w(COL_SLOTS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear_i,
    input  logic                        done_i,
    input  logic                        flt_vld_i,
    input  logic [ROW_AW-1:0]           flt_row_i,
    input  logic [COL_AW-1:0]           flt_col_i,
    output logic [ROW_SLOTS*ROW_AW-1:0] row_addr_o,
    output logic [COL_SLOTS*COL_AW-1:0] col_addr_o,
    output logic [ROW_SLOTS-1:0]        row_used_o,
    output logic [COL_SLOTS-1:0]        col_used_o,
    output logic [N*N-1:0]              conn_o,
    output logic                        overflow_o
);

    logic           row_hit, row_full, col_hit, col_full;
    logic [RIW-1:0] row_hit_idx, row_free_idx, row_idx;
    logic [CIW-1:0] col_hit_idx, col_free_idx, col_idx;
    logic           row_alloc, col_alloc, accept;
    logic           sealed_q, overflow_q;
    fgm_act_e       act;
    logic [ROW_SLOTS*COL_SLOTS-1:0] adj;

    // Decide what happens to the presented fault.
    always_comb begin
        accept = flt_vld_i && !sealed_q && !clear_i;
        if (!accept)
            act = ACT_NONE;
        else if ((!row_hit && row_full) || (!col_hit && col_full))
            act = ACT_OVERFLOW;
        else
            act = ACT_RECORD;
    end

    assign row_alloc = (act == ACT_RECORD) && !row_hit;
    assign col_alloc = (act == ACT_RECORD) && !col_hit;
    assign row_idx   = row_hit ? row_hit_idx : row_free_idx;
    assign col_idx   = col_hit ? col_hit_idx : col_free_idx;

    fgm_slot_table #(.SLOTS(ROW_SLOTS), .AW(ROW_AW)) u_rows (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .alloc_i(row_alloc),
        .key_i(flt_row_i), .hit_o(row_hit), .hit_idx_o(row_hit_idx),
        .full_o(row_full), .free_idx_o(row_free_idx),
        .addr_o(row_addr_o), .used_o(row_used_o)
    );

    fgm_slot_table #(.SLOTS(COL_SLOTS), .AW(COL_AW)) u_cols (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .alloc_i(col_alloc),
        .key_i(flt_col_i), .hit_o(col_hit), .hit_idx_o(col_hit_idx),
        .full_o(col_full), .free_idx_o(col_free_idx),
        .addr_o(col_addr_o), .used_o(col_used_o)
    );

    fgm_adj_matrix #(.ROWS(ROW_SLOTS), .COLS(COL_SLOTS)) u_adj (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i),
        .set_i(act == ACT_RECORD), .row_idx_i(row_idx), .col_idx_i(col_idx),
        .adj_o(adj)
    );

    fgm_conn_expand #(.ROWS(ROW_SLOTS), .COLS(COL_SLOTS)) u_exp (
        .adj_i(adj), .conn_o(conn_o)
    );

    // Freeze after done; clear lifts the freeze.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) sealed_q <= 1'b0;
        else if (done_i)       sealed_q <= 1'b1;
    end

    // Sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)         overflow_q <= 1'b0;
        else if (act == ACT_OVERFLOW)  overflow_q <= 1'b1;
    end

    assign overflow_o = overflow_q;

    p_clear_empties_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (row_used_o == '0 && col_used_o == '0 && conn_o == '0 && !overflow_o));

    p_overflow_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow_o && !clear_i) |=> overflow_o);

    p_overflow_discard_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_OVERFLOW) |=> ($stable(row_used_o) && $stable(col_used_o) && $stable(conn_o)));

    p_sealed_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sealed_q && !clear_i) |=> ($stable(row_used_o) && $stable(col_used_o) && $stable(conn_o)));

    // Every set crossing joins two occupied slots; the matrix is symmetric.
    for (genvar r = 0; r < ROW_SLOTS; r++) begin : g_ar
        for (genvar c = 0; c < COL_SLOTS; c++) begin : g_ac
            p_edge_has_vertices_r5: assert property (@(posedge clk) disable iff (!rst_n)
                conn_o[r*N + ROW_SLOTS + c] |-> (row_used_o[r] && col_used_o[c]));
            p_symmetric_r6: assert property (@(posedge clk) disable iff (!rst_n)
                conn_o[r*N + ROW_SLOTS + c] == conn_o[(ROW_SLOTS + c)*N + r]);
        end
    end

endmodule

// File: tb/sim_fault_graph_mapper.sv
// Bench: directed corner cases plus seeded random faults, against a model.
module sim_fault_graph_mapper;

    localparam int CLK_PERIOD = 10;
    localparam int RA = 10;
    localparam int CA = 10;
    localparam int RS = 4;
    localparam int CS = 4;
    localparam int N  = RS + CS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clear = 1'b0, done = 1'b0, vld = 1'b0;
    logic [RA-1:0] frow = '0;
    logic [CA-1:0] fcol = '0;
    logic [RS*RA-1:0] row_addr;
    logic [CS*CA-1:0] col_addr;
    logic [RS-1:0] row_used;
    logic [CS-1:0] col_used;
    logic [N*N-1:0] conn;
    logic ovf;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Model state
    int unsigned mrow [RS];
    int unsigned mcol [CS];
    int rcnt, ccnt;
    bit madj [RS][CS];
    bit movf, msealed;

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_graph_mapper #(.ROW_AW(RA), .COL_AW(CA), .ROW_SLOTS(RS), .COL_SLOTS(CS)) u0 (
        .clk(clk), .rst_n(rst_n), .clear_i(clear), .done_i(done),
        .flt_vld_i(vld), .flt_row_i(frow), .flt_col_i(fcol),
        .row_addr_o(row_addr), .col_addr_o(col_addr),
        .row_used_o(row_used), .col_used_o(col_used),
        .conn_o(conn), .overflow_o(ovf)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        rcnt = 0; ccnt = 0; movf = 0; msealed = 0;
        for (int r = 0; r < RS; r++) for (int c = 0; c < CS; c++) madj[r][c] = 0;
    endtask

    task automatic model_update(input bit v, input int unsigned r, input int unsigned c,
                                input bit clr, input bit dn);
        int ri, ci;
        if (clr) begin
            model_clear();
            return;
        end
        if (v && !msealed) begin
            ri = -1; ci = -1;
            for (int k = 0; k < rcnt; k++) if (mrow[k] == r) ri = k;
            for (int k = 0; k < ccnt; k++) if (mcol[k] == c) ci = k;
            if ((ri < 0 && rcnt == RS) || (ci < 0 && ccnt == CS)) begin
                movf = 1;
            end else begin
                if (ri < 0) begin ri = rcnt; mrow[rcnt] = r; rcnt++; end
                if (ci < 0) begin ci = ccnt; mcol[ccnt] = c; ccnt++; end
                madj[ri][ci] = 1;
            end
        end
        if (dn) msealed = 1;
    endtask

    function automatic logic [N*N-1:0] exp_conn();
        logic [N*N-1:0] e = '0;
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                if (i < RS && j >= RS) e[i*N+j] = madj[i][j-RS];
                if (i >= RS && j < RS) e[i*N+j] = madj[j][i-RS];
            end
        return e;
    endfunction

    task automatic check_all();
        logic [RS-1:0] eru = RS'((1 << rcnt) - 1);
        logic [CS-1:0] ecu = CS'((1 << ccnt) - 1);
        bit aok = 1;
        bit sym = 1;
        logic [N*N-1:0] ec = exp_conn();
        chk(row_used == eru, "R2", "row_used", row_used, eru);
        chk(col_used == ecu, "R3", "col_used", col_used, ecu);
        for (int k = 0; k < rcnt; k++) if (row_addr[k*RA +: RA] != RA'(mrow[k])) aok = 0;
        for (int k = 0; k < ccnt; k++) if (col_addr[k*CA +: CA] != CA'(mcol[k])) aok = 0;
        chk(aok, "R4", "slot addresses", row_addr, {col_addr});
        chk(conn == ec, "R5", "conn", conn, ec);
        chk(ovf == movf, "R7", "overflow", ovf, movf);
        for (int i = 0; i < N; i++) begin
            if (conn[i*N+i]) sym = 0;
            for (int j = 0; j < N; j++) begin
                if (conn[i*N+j] != conn[j*N+i]) sym = 0;
                if ((i < RS) == (j < RS) && conn[i*N+j]) sym = 0;
            end
        end
        chk(sym, "R6", "symmetry/diagonal", conn, ec);
    endtask

    task automatic step(input bit v, input int unsigned r, input int unsigned c,
                        input bit clr, input bit dn);
        vld = v; frow = RA'(r); fcol = CA'(c); clear = clr; done = dn;
        model_update(v, r, c, clr, dn);
        @(negedge clk);
        check_all();
        vld = 0; clear = 0; done = 0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N*N-1:0] snap;
        void'($urandom(32'd20240611));
        model_clear();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(row_used == 0 && col_used == 0 && conn == 0 && !ovf, "R1", "reset state",
            {row_used, col_used}, 0);
        rst_n = 1;
        @(negedge clk);

        // R10: not visible before the edge, visible after it
        vld = 1; frow = 10'd42; fcol = 10'd37;
        #1;
        chk(row_used == 0 && conn == 0, "R10", "before edge", row_used, 0);
        model_update(1, 42, 37, 0, 0);
        @(negedge clk);
        vld = 0;
        check_all();

        // Example graph: rows 42,118,629,823 and columns 37,125,225,921
        step(1, 118, 125, 0, 0);
        step(1, 629, 225, 0, 0);
        step(1, 823, 921, 0, 0);
        step(1, 42, 921, 0, 0);
        chk(row_addr[0 +: RA] == 10'd42 && row_addr[3*RA +: RA] == 10'd823, "R2",
            "row order", row_addr, 0);
        chk(col_addr[3*CA +: CA] == 10'd921 && col_addr[0 +: CA] == 10'd37, "R3",
            "col order", col_addr, 0);
        chk(conn[0*N + 7] && conn[7*N + 0], "R5", "crossing 42/921", conn, 1);

        // R8: duplicate report
        snap = conn;
        step(1, 42, 37, 0, 0);
        chk(conn == snap && row_used == 4'hF && col_used == 4'hF, "R8", "duplicate",
            conn, snap);

        // R4: reuse existing row and column
        step(1, 118, 37, 0, 0);
        chk(row_used == 4'hF && col_used == 4'hF && conn[1*N + 4], "R4", "reuse",
            {row_used, col_used}, 8'hFF);

        // R7: new row with full row table
        snap = conn;
        step(1, 500, 37, 0, 0);
        chk(ovf && conn == snap, "R7", "overflow discard", ovf, 1);
        step(1, 629, 125, 0, 0);
        chk(ovf, "R7", "overflow sticky", ovf, 1);

        // R1: clear wins over a simultaneous fault
        step(1, 7, 7, 1, 0);
        chk(row_used == 0 && col_used == 0 && conn == 0 && !ovf, "R1", "clear priority",
            {row_used, col_used}, 0);

        // R7: rows full, column table not full, new row and new column
        step(1, 1, 1, 0, 0);
        step(1, 2, 1, 0, 0);
        step(1, 3, 1, 0, 0);
        step(1, 4, 1, 0, 0);
        step(1, 5, 9, 0, 0);
        chk(col_used == 4'h1 && ovf, "R7", "one-sided overflow", col_used, 1);

        // R9: fault with done recorded, later faults ignored
        step(1, 0, 0, 1, 0);
        step(1, 5, 6, 0, 1);
        chk(row_used == 4'h1 && col_used == 4'h1, "R9", "fault with done", row_used, 1);
        step(1, 7, 8, 0, 0);
        chk(row_used == 4'h1 && col_used == 4'h1 && !ovf, "R9", "ignored after done",
            row_used, 1);
        step(0, 0, 0, 1, 0);

        // Random phase: small address pools to mix hits, misses and overflow
        for (int n = 0; n < 1500; n++) begin
            int unsigned pr = $urandom % 6;
            int unsigned pc = $urandom % 6;
            int unsigned x  = $urandom % 100;
            step(x < 70, pr * 37 + 3, pc * 53 + 11, x == 99, x == 98);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule